// File: doc/BRIEF.md
# Processing Element Operand Fetch

This block supplies the second operand to one processing element of a single-instruction, multiple-data array. The control unit sends the same request to every element over a shared broadcast bus. A request has a field and a two-bit kind tag, and the tag decides how each element reads the field. A memory operand is a base address. The element adds its own private index register to that base before it reads or writes its local memory, so one instruction stream can reach data that sits at a different place in each element. A register operand picks one of the element's four local data registers. A constant operand is the field itself, zero-extended.

The fetched value comes back one cycle after the request. It is presented beside the accumulator, which is always the first operand of a one-address instruction. A store writes the accumulator into local memory at the indexed address. When the element's enable input is low the store is dropped. The local registers and the index are written through a separate load port.

Top module: `pe_opnd_fetch`

## Requirements
- R1: Synchronous active-high reset clears the output valid flag, the operand output, the accumulator output, the four data registers and the index register.
- R2: The memory address is (field[ADDR_W-1:0] + index) modulo 2^ADDR_W. It is 11 bits by default, so the local memory holds 2048 words.
- R3: A load with kind 2'b00 returns the memory word at the indexed address.
- R4: A store with kind 2'b00 and enable high writes the accumulator to the indexed address. With enable low, memory is left unchanged.
- R5: A load with kind 2'b01 returns a data register chosen by field[1:0]: 0 is the accumulator, 1 the operand buffer, 2 the scratch register and 3 the routing register. Upper field bits are ignored. The value is the one held before any register write on the same edge.
- R6: A load with kind 2'b10 returns the field zero-extended to the data width.
- R7: The operand valid flag is high exactly in the cycle after a load request (bc_valid high, bc_store low). Stores and idle cycles leave it low.
- R8: A store whose kind is not 2'b00 changes neither memory nor any register.
- R9: A load with the spare kind 2'b11 returns zero.
- R10: The accumulator output shows a value written to the accumulator from the cycle after the write.
- R11: The load port writes the accumulator, operand buffer, scratch, routing and index registers for selects 0, 1, 2, 3 and 4 respectively, whatever the enable input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pe_en | input | 1 | Element enable; gates memory stores |
| bc_valid | input | 1 | Broadcast request strobe |
| bc_store | input | 1 | 1 = store accumulator, 0 = load operand |
| bc_kind | input | 2 | Operand kind: 00 memory, 01 register, 10 constant, 11 spare |
| bc_field | input | FIELD_W | Broadcast address, register number or literal |
| ld_we | input | 1 | Local register write strobe |
| ld_sel | input | 3 | Register to write: 0 acc, 1 buffer, 2 scratch, 3 routing, 4 index |
| ld_data | input | DATA_W | Register write data |
| opnd_valid | output | 1 | Operand valid, one cycle after a load |
| opnd_data | output | DATA_W | Fetched second operand |
| acc_out | output | DATA_W | Accumulator, the first operand |

## Verification
Two elements are given different index values and receive one common broadcast stream. One index makes base plus index pass the top of memory. If the design dropped the index, or kept the carry out of the adder, both elements would hit the same word or the element with the wrapping index would miss its word. A store issued while one element is disabled must change only the enabled element's word; an ungated write port would overwrite both. A store tagged as a register operand must leave memory and registers alone. Register and constant reads are checked against values set per element, including a field with high bits set. This catches a register select that decodes more than two bits and a constant path that sign-extends.

// File: rtl/pe_fetch_pkg.sv
package pe_fetch_pkg;

  typedef enum logic [1:0] {
    KIND_MEM   = 2'b00,
    KIND_REG   = 2'b01,
    KIND_CONST = 2'b10,
    KIND_SPARE = 2'b11
  } opnd_kind_e;

  typedef enum logic [2:0] {
    LSEL_ACC   = 3'd0,
    LSEL_BUF   = 3'd1,
    LSEL_SCR   = 3'd2,
    LSEL_ROUTE = 3'd3,
    LSEL_INDEX = 3'd4
  } ld_sel_e;

  localparam int NUM_DATA_REGS = 4;

endpackage

// File: rtl/pe_addr_gen.sv
module pe_addr_gen #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W:0] sum;

  // Carry out is dropped, giving the modulo-depth wrap.
  always_comb begin
    sum      = {1'b0, base} + {1'b0, index};
    eff_addr = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/pe_local_regs.sv
module pe_local_regs
  import pe_fetch_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [2:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] index
);
  logic [DATA_W-1:0] regs [NUM_DATA_REGS];

  for (genvar g = 0; g < NUM_DATA_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (ld_we && ld_sel == 3'(g)) begin
        regs[g] <= ld_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
    end else if (ld_we && ld_sel == LSEL_INDEX) begin
      index <= ld_data[ADDR_W-1:0];
    end
  end

  always_comb begin
    rd_data = regs[rd_sel];
    acc     = regs[0];
  end
endmodule

// File: rtl/pe_local_mem.sv
module pe_local_mem #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, read-first, registered read: maps to one block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pe_opnd_fetch.sv
module pe_opnd_fetch
  import pe_fetch_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 11,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pe_en,
  input  logic               bc_valid,
  input  logic               bc_store,
  input  logic [1:0]         bc_kind,
  input  logic [FIELD_W-1:0] bc_field,
  input  logic               ld_we,
  input  logic [2:0]         ld_sel,
  input  logic [DATA_W-1:0]  ld_data,
  output logic               opnd_valid,
  output logic [DATA_W-1:0]  opnd_data,
  output logic [DATA_W-1:0]  acc_out
);
  logic              load_req;
  logic              store_req;
  logic [ADDR_W-1:0] index;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] alt_d;
  logic [DATA_W-1:0] alt_q;
  opnd_kind_e        kind_in;
  opnd_kind_e        kind_q;
  logic              vld_q;

  always_comb begin
    kind_in   = opnd_kind_e'(bc_kind);
    load_req  = bc_valid && !bc_store;
    store_req = bc_valid && bc_store && (kind_in == KIND_MEM) && pe_en;
  end

  pe_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .base    (bc_field[ADDR_W-1:0]),
    .index   (index),
    .eff_addr(eff_addr)
  );

  pe_local_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ld_we  (ld_we),
    .ld_sel (ld_sel),
    .ld_data(ld_data),
    .rd_sel (bc_field[1:0]),
    .rd_data(reg_rd),
    .acc    (acc_out),
    .index  (index)
  );

  pe_local_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (store_req),
    .addr (eff_addr),
    .wdata(acc_out),
    .rdata(mem_q)
  );

  // Non-memory sources are registered so all kinds share one latency.
  always_comb begin
    unique case (kind_in)
      KIND_REG:   alt_d = reg_rd;
      KIND_CONST: alt_d = DATA_W'(bc_field);
      default:    alt_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      kind_q <= KIND_SPARE;
      alt_q  <= '0;
    end else begin
      vld_q <= load_req;
      if (load_req) begin
        kind_q <= kind_in;
        alt_q  <= alt_d;
      end
    end
  end

  always_comb begin
    opnd_valid = vld_q;
    opnd_data  = (kind_q == KIND_MEM) ? mem_q : alt_q;
  end
endmodule

// File: rtl/pe_opnd_fetch_chk.sv
module pe_opnd_fetch_chk #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 11,
  parameter int FIELD_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bc_valid,
  input logic               bc_store,
  input logic [1:0]         bc_kind,
  input logic [FIELD_W-1:0] bc_field,
  input logic               ld_we,
  input logic [2:0]         ld_sel,
  input logic [DATA_W-1:0]  ld_data,
  input logic               opnd_valid,
  input logic [DATA_W-1:0]  opnd_data,
  input logic [DATA_W-1:0]  acc_out
);
  logic was_rst = 1'b0;

  always @(posedge clk) begin
    if (was_rst) begin
      assert_reset_clears_R1: assert (!opnd_valid && opnd_data == '0 && acc_out == '0)
        else $error("reset state not clear");
    end
    was_rst <= rst;
  end

  assert_valid_after_load_R7: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_store) |=> opnd_valid);

  assert_no_valid_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
    !(bc_valid && !bc_store) |=> !opnd_valid);

  assert_acc_operand_R5: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_store && bc_kind == 2'b01 && bc_field[1:0] == 2'b00)
      |=> opnd_data == $past(acc_out));

  assert_const_zero_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_store && bc_kind == 2'b10)
      |=> opnd_data == DATA_W'($past(bc_field)));

  assert_spare_kind_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_store && bc_kind == 2'b11) |=> opnd_data == '0);

  assert_acc_follows_write_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_we && ld_sel == 3'd0) |=> acc_out == $past(ld_data));
endmodule

bind pe_opnd_fetch pe_opnd_fetch_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst(rst), .bc_valid(bc_valid), .bc_store(bc_store),
  .bc_kind(bc_kind), .bc_field(bc_field), .ld_we(ld_we), .ld_sel(ld_sel),
  .ld_data(ld_data), .opnd_valid(opnd_valid), .opnd_data(opnd_data),
  .acc_out(acc_out)
);

// File: tb/pe_opnd_fetch_tb.sv
module pe_opnd_fetch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int FW = 16;

  localparam logic [DW-1:0] A0V = 64'h1111_0000_0000_00A0;
  localparam logic [DW-1:0] A1V = 64'h2222_0000_0000_00A1;
  localparam logic [DW-1:0] B0V = 64'h3333_0000_0000_00B0;
  localparam logic [DW-1:0] B1V = 64'h4444_0000_0000_00B1;
  localparam logic [DW-1:0] S0V = 64'h5555_0000_0000_0050;
  localparam logic [DW-1:0] S1V = 64'h6666_0000_0000_0051;
  localparam logic [DW-1:0] R0V = 64'h7777_0000_0000_0070;
  localparam logic [DW-1:0] R1V = 64'h8888_0000_0000_0071;
  localparam logic [DW-1:0] C0V = 64'h9999_0000_0000_00C0;
  localparam logic [DW-1:0] C1V = 64'hAAAA_0000_0000_00C1;

  typedef struct packed {
    logic [1:0]    kind;
    logic [FW-1:0] field;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 16'h0000, A0V, A1V},
    '{2'b01, 16'h0001, B0V, B1V},
    '{2'b01, 16'h0002, S0V, S1V},
    '{2'b01, 16'h0003, R0V, R1V},
    '{2'b01, 16'hFFF1, B0V, B1V},
    '{2'b10, 16'h1234, 64'h1234, 64'h1234},
    '{2'b10, 16'hFFFF, 64'hFFFF, 64'hFFFF},
    '{2'b11, 16'h0ABC, 64'h0, 64'h0},
    '{2'b00, 16'h000A, A0V, A1V}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bc_valid = 1'b0;
  logic          bc_store = 1'b0;
  logic [1:0]    bc_kind = 2'b00;
  logic [FW-1:0] bc_field = '0;
  logic          en0 = 1'b1, en1 = 1'b1;
  logic          we0 = 1'b0, we1 = 1'b0;
  logic [2:0]    sel0 = '0, sel1 = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic          v0, v1;
  logic [DW-1:0] d0, d1, acc0, acc1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_opnd_fetch #(.DATA_W(DW), .ADDR_W(11), .FIELD_W(FW)) u_dut (
    .clk(clk), .rst(rst), .pe_en(en0), .bc_valid(bc_valid), .bc_store(bc_store),
    .bc_kind(bc_kind), .bc_field(bc_field), .ld_we(we0), .ld_sel(sel0),
    .ld_data(wd0), .opnd_valid(v0), .opnd_data(d0), .acc_out(acc0)
  );

  pe_opnd_fetch #(.DATA_W(DW), .ADDR_W(11), .FIELD_W(FW)) u_dut_b (
    .clk(clk), .rst(rst), .pe_en(en1), .bc_valid(bc_valid), .bc_store(bc_store),
    .bc_kind(bc_kind), .bc_field(bc_field), .ld_we(we1), .ld_sel(sel1),
    .ld_data(wd1), .opnd_valid(v1), .opnd_data(d1), .acc_out(acc1)
  );

  task automatic check(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic set_reg(input bit inst, input logic [2:0] sel, input logic [DW-1:0] val);
    @(negedge clk);
    if (inst) begin we1 = 1'b1; sel1 = sel; wd1 = val; end
    else      begin we0 = 1'b1; sel0 = sel; wd0 = val; end
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  // Drives one request for one edge; returns at the next negedge, where results are visible.
  task automatic bcast(input logic st, input logic [1:0] kind, input logic [FW-1:0] field);
    @(negedge clk);
    bc_valid = 1'b1;
    bc_store = st;
    bc_kind  = kind;
    bc_field = field;
    @(negedge clk);
    bc_valid = 1'b0;
    bc_store = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] kind);
    case (kind)
      2'b00:   return "R3";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the ports
    check("R1 valid0", {63'b0, v0}, 64'd0);
    check("R1 valid1", {63'b0, v1}, 64'd0);
    check("R1 data0", d0, 64'd0);
    check("R1 acc0", acc0, 64'd0);
    check("R1 acc1", acc1, 64'd0);
    bcast(1'b0, 2'b01, 16'h0001);
    check("R1 buffer cleared", d0, 64'd0);
    check("R7 valid after load", {63'b0, v0}, 64'd1);

    // R11: load port writes every register
    set_reg(0, 3'd0, A0V); set_reg(1, 3'd0, A1V);
    check("R10 acc0 after write", acc0, A0V);
    check("R10 acc1 after write", acc1, A1V);
    set_reg(0, 3'd1, B0V); set_reg(1, 3'd1, B1V);
    set_reg(0, 3'd2, S0V); set_reg(1, 3'd2, S1V);
    set_reg(0, 3'd3, R0V); set_reg(1, 3'd3, R1V);
    set_reg(0, 3'd4, 64'd5); set_reg(1, 3'd4, 64'd2040);

    // R2 R4: store base 10 -> word 15 in u_dut, word 2 (wrapped) in u_dut_b
    bcast(1'b1, 2'b00, 16'h000A);
    check("R7 no valid on store", {63'b0, v0}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      bcast(1'b0, VEC[i].kind, VEC[i].field);
      check({tag_of(VEC[i].kind), " vec u_dut"}, d0, VEC[i].e0);
      check({tag_of(VEC[i].kind), " vec u_dut_b"}, d1, VEC[i].e1);
      check("R7 vec valid", {62'b0, v0, v1}, 64'd3);
    end

    // R4: disabled element must not store
    set_reg(0, 3'd0, C0V); set_reg(1, 3'd0, C1V);
    en1 = 1'b0;
    bcast(1'b1, 2'b00, 16'h000A);
    en1 = 1'b1;
    bcast(1'b0, 2'b00, 16'h000A);
    check("R4 enabled store", d0, C0V);
    check("R4 disabled store kept", d1, A1V);

    // R8: store tagged register kind has no effect
    bcast(1'b1, 2'b01, 16'h000A);
    check("R7 no valid on reg store", {62'b0, v0, v1}, 64'd0);
    bcast(1'b0, 2'b00, 16'h000A);
    check("R8 mem u_dut", d0, C0V);
    check("R8 mem u_dut_b", d1, A1V);
    bcast(1'b0, 2'b01, 16'h0002);
    check("R8 scratch u_dut", d0, S0V);
    check("R8 scratch u_dut_b", d1, S1V);

    // R2: absolute words confirmed with a zero index
    set_reg(0, 3'd4, 64'd0); set_reg(1, 3'd4, 64'd0);
    bcast(1'b0, 2'b00, 16'h000F);
    check("R2 u_dut word 15", d0, C0V);
    bcast(1'b0, 2'b00, 16'h0002);
    check("R2 u_dut_b wrapped word 2", d1, A1V);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule